// File: doc/BRIEF.md
# Synchronous Burst SRAM Model with Flow-Through Reads

This block is a synthesizable model of a single-port synchronous burst SRAM. Its word is made of byte lanes, nine bits each by default. Address, write data, chip enables, write enables and burst controls are all captured on the rising clock edge. A new external address can be loaded by either of two strobes, each with its own rule for the primary enable.

Once an address is loaded, a 2-bit counter steps through the four-word block that holds it. The counter advances when the advance input is asserted. The order is linear or interleaved, chosen by a static mode pin.

Writes are selected by a three-level hierarchy: a global write, then a byte-write gate, then one enable per lane. Read data leaves combinationally from the registered address in the cycle after the capture edge. A registered valid flag marks read cycles on a selected device. The valid flag takes the place of a pad output enable.

An asynchronous sleep input freezes the whole block. While it is high, every other input is ignored and the stored data is kept.

Top module: `sbsram_core`

## Requirements
- R1: After synchronous reset `rvalid_o` is low and no burst is active, so a following continuation cycle with `adv_n` low still shows `rvalid_o` low.
- R2: `ld_proc_n` low with `ce_n` low and both secondary enables selecting loads `addr_i` and performs a read whatever the write enables are. In the next cycle `rvalid_o` is high and `rdata_o` holds the word at that address.
- R3: `ld_proc_n` low while `ce_n` is high is ignored: the current burst carries on as a continuation cycle.
- R4: `ld_ctrl_n` low with `ce_n` low (and `ld_proc_n` not loading) loads `addr_i`. That access is a write or a read, as set by the write enables of the same cycle.
- R5: `ld_ctrl_n` low with `ce_n` high powers the device down. `rvalid_o` goes low, and later continuation cycles neither read nor write until a new load.
- R6: A load cycle with `ce2_hi` low or `ce2_n` high powers the device down, with the same effect as R5.
- R7: With no load, `adv_n` low steps the burst counter. `adv_n` high keeps the address, so the access repeats at the same word; a write may use this after a `ld_proc_n` load.
- R8: With `order_mode_i` = 0 (linear), the two low address bits are the loaded low bits plus the count, modulo 4. The upper address bits never change during a burst.
- R9: With `order_mode_i` = 1 (interleaved), the two low address bits are the loaded low bits XOR the count, which runs 0 to 3.
- R10: `gw_n` low writes all bits of the word, whatever `bwe_n` and `bw_n` are.
- R11: With `gw_n` high and `bwe_n` low, `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. A cycle with no lane selected, or with `bwe_n` high, is a read.
- R12: While `snooze_i` is high, `rvalid_o` is low, all other inputs are ignored, memory contents are kept and the burst state is held.
- R13: Reads are flow-through: `rdata_o` shows the addressed word in the cycle right after the capture edge, with no further pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| snooze_i | input | 1 | Asynchronous sleep; freezes the block |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANE_W*LANES | Write data |
| ld_proc_n | input | 1 | Processor-type address load strobe, active low |
| ld_ctrl_n | input | 1 | Controller-type address load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_hi | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| order_mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | LANE_W*LANES | Flow-through read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
A load strobe can fall in the same cycle as a write request. In that cycle the load rules must decide whether the write enables count. The bench provokes this by holding `gw_n` low during a processor-type load, which must give a read and leave the word unchanged. It also loads under a power-down rule while a write is requested, then reads back the words a leaked write could have changed. A third case asserts sleep together with a controller-type write load, and judges it by reading the target word once sleep ends.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int CNT_W = 2;

    typedef enum logic {
        BURST_LIN = 1'b0,
        BURST_ILV = 1'b1
    } burst_mode_e;

    typedef struct packed {
        logic load;
        logic sleep;
        logic force_rd;
    } ld_cmd_t;

    function automatic logic [CNT_W-1:0] burst_lo(
        input logic [CNT_W-1:0] base,
        input logic [CNT_W-1:0] cnt,
        input burst_mode_e      mode
    );
        return (mode == BURST_ILV) ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/sbsram_load_ctl.sv
module sbsram_load_ctl
    import sbsram_pkg::*;
(
    input  logic    ld_proc_n,
    input  logic    ld_ctrl_n,
    input  logic    ce_n,
    input  logic    ce2_hi,
    input  logic    ce2_n,
    output ld_cmd_t cmd
);
    logic proc_take;
    logic ctrl_take;
    logic sec_ok;

    always_comb begin
        // processor strobe only counts with the primary enable low
        proc_take    = !ld_proc_n && !ce_n;
        ctrl_take    = !proc_take && !ld_ctrl_n;
        sec_ok       = ce2_hi && !ce2_n;
        cmd.load     = (proc_take || (ctrl_take && !ce_n)) && sec_ok;
        cmd.sleep    = (proc_take && !sec_ok) ||
                       (ctrl_take && (ce_n || !sec_ok));
        cmd.force_rd = proc_take;
    end
endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] wmask
);
    always_comb begin
        if (!gw_n)
            wmask = '1;
        else if (!bwe_n)
            wmask = ~bw_n;
        else
            wmask = '0;
    end
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              load,
    input  logic              sleep,
    input  logic              advance,
    input  burst_mode_e       mode,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              cur_act,
    output logic              nxt_act
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic [UP_W-1:0]  upper_q, upper_n;
    logic [CNT_W-1:0] base_q,  base_n;
    logic [CNT_W-1:0] cnt_q,   cnt_n;
    logic             act_q,   act_n;

    always_comb begin
        upper_n = upper_q;
        base_n  = base_q;
        cnt_n   = cnt_q;
        act_n   = act_q;
        if (load) begin
            upper_n = ld_addr[ADDR_W-1:CNT_W];
            base_n  = ld_addr[CNT_W-1:0];
            cnt_n   = '0;
            act_n   = 1'b1;
        end else if (sleep) begin
            act_n   = 1'b0;
        end else if (act_q && advance) begin
            cnt_n   = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
        end else if (!hold) begin
            upper_q <= upper_n;
            base_q  <= base_n;
            cnt_q   <= cnt_n;
            act_q   <= act_n;
        end
    end

    assign cur_addr = {upper_q, burst_lo(base_q, cnt_q, mode)};
    assign nxt_addr = {upper_n, burst_lo(base_n, cnt_n, mode)};
    assign cur_act  = act_q;
    assign nxt_act  = act_n;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANE_W*LANES-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANE_W*LANES-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    snooze_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANE_W*LANES-1:0] wdata_i,
    input  logic                    ld_proc_n,
    input  logic                    ld_ctrl_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ce2_hi,
    input  logic                    ce2_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    order_mode_i,
    output logic [LANE_W*LANES-1:0] rdata_o,
    output logic                    rvalid_o
);
    ld_cmd_t           cmd;
    logic [LANES-1:0]  wmask_raw;
    logic [LANES-1:0]  wmask;
    logic [LANES-1:0]  we;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic              cur_act;
    logic              nxt_act;
    logic              rvalid_q;

    sbsram_load_ctl u_ld (
        .ld_proc_n (ld_proc_n),
        .ld_ctrl_n (ld_ctrl_n),
        .ce_n      (ce_n),
        .ce2_hi    (ce2_hi),
        .ce2_n     (ce2_n),
        .cmd       (cmd)
    );

    sbsram_wr_decode #(.LANES(LANES)) u_wd (
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .wmask (wmask_raw)
    );

    sbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .hold     (snooze_i),
        .load     (cmd.load),
        .sleep    (cmd.sleep),
        .advance  (!adv_n),
        .mode     (burst_mode_e'(order_mode_i)),
        .ld_addr  (addr_i),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr),
        .cur_act  (cur_act),
        .nxt_act  (nxt_act)
    );

    // a processor-strobe load is always a read; a deselected device writes nothing
    assign wmask = (cmd.force_rd || !nxt_act) ? '0 : wmask_raw;
    assign we    = (snooze_i || rst) ? '0 : wmask;

    sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (nxt_addr),
        .wdata (wdata_i),
        .raddr (cur_addr),
        .rdata (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rvalid_q <= 1'b0;
        else if (!snooze_i)
            rvalid_q <= nxt_act && (wmask == '0);
    end

    assign rvalid_o = rvalid_q && !snooze_i;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              snooze_i,
    input logic              ld_proc_n,
    input logic              ld_ctrl_n,
    input logic              ce_n,
    input logic              ce2_hi,
    input logic              ce2_n,
    input logic              adv_n,
    input logic              rvalid_o,
    input logic              cur_act,
    input logic [ADDR_W-1:0] cur_addr
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst_d |-> !rvalid_o);

    assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
        (!snooze_i && !ld_proc_n && !ce_n && ce2_hi && !ce2_n)
        |=> (rvalid_o || snooze_i));

    assert_ctrl_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        (!snooze_i && !ld_ctrl_n && ce_n) |=> !rvalid_o);

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!snooze_i && ld_proc_n && ld_ctrl_n && adv_n && cur_act)
        |=> $stable(cur_addr));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (!snooze_i && ld_proc_n && ld_ctrl_n && cur_act)
        |=> $stable(cur_addr[ADDR_W-1:2]));

    assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        snooze_i |-> !rvalid_o);
endmodule

bind sbsram_core sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .snooze_i  (snooze_i),
    .ld_proc_n (ld_proc_n),
    .ld_ctrl_n (ld_ctrl_n),
    .ce_n      (ce_n),
    .ce2_hi    (ce2_hi),
    .ce2_n     (ce2_n),
    .adv_n     (adv_n),
    .rvalid_o  (rvalid_o),
    .cur_act   (cur_act),
    .cur_addr  (cur_addr)
);

// File: tb/sbsram_core_bench.sv
module sbsram_core_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        snooze_i;
    logic [7:0]  addr_i;
    logic [17:0] wdata_i;
    logic        ld_proc_n, ld_ctrl_n, adv_n;
    logic        ce_n, ce2_hi, ce2_n;
    logic        gw_n, bwe_n;
    logic [1:0]  bw_n;
    logic        order_mode_i;
    logic [17:0] rdata_o;
    logic        rvalid_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit          cv;
        bit          ev;
        bit          cd;
        logic [17:0] ed;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    sbsram_core u_sbsram_core (
        .clk(clk), .rst(rst), .snooze_i(snooze_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .ld_proc_n(ld_proc_n), .ld_ctrl_n(ld_ctrl_n),
        .adv_n(adv_n), .ce_n(ce_n), .ce2_hi(ce2_hi), .ce2_n(ce2_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .order_mode_i(order_mode_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic idle();
        ld_proc_n = 1; ld_ctrl_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 2'b11; wdata_i = '0;
        ce_n = 0; ce2_hi = 1; ce2_n = 0;
    endtask

    task automatic step(input bit cv, input bit ev, input bit cd,
                        input logic [17:0] ed, input string tag);
        exp_t e;
        e.cv = cv; e.ev = ev; e.cd = cd; e.ed = ed; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        idle();
    endtask

    task automatic proc_ld(input logic [7:0] a);
        ld_proc_n = 0; addr_i = a;
    endtask

    task automatic ctrl_ld(input logic [7:0] a);
        ld_ctrl_n = 0; addr_i = a;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // monitor: compares each cycle's results with the queued expectation
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                if (e.cv) begin
                    total++;
                    if (rvalid_o !== e.ev) begin
                        bad++;
                        $display("FAIL %s valid actual=%0b expected=%0b", e.tag, rvalid_o, e.ev);
                    end
                end
                if (e.cd) begin
                    total++;
                    if (rdata_o !== e.ed) begin
                        bad++;
                        $display("FAIL %s data actual=%h expected=%h", e.tag, rdata_o, e.ed);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [17:0] A0 = 18'h0A0A0, A1 = 18'h0A1A1,
                            A2 = 18'h0A2A2, A3 = 18'h0A3A3;

    initial begin
        idle();
        snooze_i = 0; order_mode_i = 0; addr_i = '0; rst = 1;
        step(1, 0, 0, '0, "R1");
        step(1, 0, 0, '0, "R1");
        rst = 0;
        adv_n = 0; step(1, 0, 0, '0, "R1");

        // fill a block with global writes, linear advance
        ctrl_ld(8'h10); gw_n = 0; wdata_i = A0; step(1, 0, 0, '0, "R4");
        adv_n = 0; gw_n = 0; wdata_i = A1; step(1, 0, 0, '0, "R10");
        adv_n = 0; gw_n = 0; wdata_i = A2; step(1, 0, 0, '0, "R10");
        adv_n = 0; gw_n = 0; wdata_i = A3; step(1, 0, 0, '0, "R10");

        // linear read from 0x11, with global write held during the load
        proc_ld(8'h11); gw_n = 0; step(1, 1, 1, A1, "R2 R13");
        adv_n = 0; step(1, 1, 1, A2, "R8");
        adv_n = 0; step(1, 1, 1, A3, "R8");
        adv_n = 0; step(1, 1, 1, A0, "R8 wrap");
        step(1, 1, 1, A0, "R7 wait");
        adv_n = 0; step(1, 1, 1, A1, "R8");

        // interleaved order from 0x11: 1,0,3,2
        order_mode_i = 1;
        proc_ld(8'h11); step(1, 1, 1, A1, "R9");
        adv_n = 0; step(1, 1, 1, A0, "R9");
        adv_n = 0; step(1, 1, 1, A3, "R9");
        adv_n = 0; step(1, 1, 1, A2, "R9");
        order_mode_i = 0;
        step(0, 0, 0, '0, "");

        // lane writes
        ctrl_ld(8'h20); gw_n = 0; step(1, 0, 0, '0, "R10");
        ctrl_ld(8'h20); bwe_n = 0; bw_n = 2'b10; wdata_i = 18'h3FFFF; step(1, 0, 0, '0, "R11");
        proc_ld(8'h20); step(1, 1, 1, 18'h001FF, "R11 lane a");
        ctrl_ld(8'h20); bwe_n = 0; bw_n = 2'b01; wdata_i = 18'h3FFFF; step(1, 0, 0, '0, "R11");
        ctrl_ld(8'h20); bwe_n = 0; bw_n = 2'b11; step(1, 1, 1, 18'h3FFFF, "R11 R4 no lane");
        ctrl_ld(8'h20); gw_n = 0; bwe_n = 0; bw_n = 2'b11; wdata_i = 18'h15A5A; step(1, 0, 0, '0, "R10");
        ctrl_ld(8'h20); bw_n = 2'b00; step(1, 1, 1, 18'h15A5A, "R11 gate off");

        // write following a processor load, with advance held high
        ctrl_ld(8'h31); gw_n = 0; wdata_i = 18'h00777; step(1, 0, 0, '0, "R4");
        proc_ld(8'h30); step(1, 1, 0, '0, "R2");
        gw_n = 0; wdata_i = 18'h0BEEF; step(1, 0, 0, '0, "R7");
        proc_ld(8'h30); step(1, 1, 1, 18'h0BEEF, "R7");

        // processor strobe ignored with primary enable high
        proc_ld(8'h40); ce_n = 1; step(1, 1, 1, 18'h0BEEF, "R3");

        // controller strobe with primary enable high: power-down
        ctrl_ld(8'h30); ce_n = 1; step(1, 0, 0, '0, "R5");
        adv_n = 0; gw_n = 0; step(1, 0, 0, '0, "R5");
        gw_n = 0; step(1, 0, 0, '0, "R5");
        proc_ld(8'h30); step(1, 1, 1, 18'h0BEEF, "R5");
        adv_n = 0; step(1, 1, 1, 18'h00777, "R5");

        // secondary enables
        proc_ld(8'h31); ce2_hi = 0; step(1, 0, 0, '0, "R6");
        adv_n = 0; gw_n = 0; step(1, 0, 0, '0, "R6");
        ctrl_ld(8'h31); ce2_n = 1; gw_n = 0; step(1, 0, 0, '0, "R6");
        gw_n = 0; step(1, 0, 0, '0, "R6");
        proc_ld(8'h30); step(1, 1, 1, 18'h0BEEF, "R6");
        adv_n = 0; step(1, 1, 1, 18'h00777, "R6");

        // sleep over an active burst at 0x31
        snooze_i = 1; ctrl_ld(8'h31); gw_n = 0; step(1, 0, 0, '0, "R12");
        adv_n = 0; step(1, 0, 0, '0, "R12");
        snooze_i = 0; step(1, 1, 1, 18'h00777, "R12 held");
        proc_ld(8'h31); step(1, 1, 1, 18'h00777, "R12 kept");

        step(0, 0, 0, '0, "");
        step(0, 0, 0, '0, "");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule